// File: doc/BRIEF.md
# Prefix-OR Unary Priority Encoder

This block turns an input word into a thermometer word: every output position from the first set input bit onward reads 1, and every position ahead of it reads 0. Position 1 is the most significant bit of the port (`in_vec[W-1]`), so output bit `b` is the OR of all input bits from the top of the word down to bit `b`. A normalisation stage can use the result directly as a mask of the positions at or after the leading one.

The OR network is a recursive parallel-prefix structure. Neighbouring pairs are combined first, a half-width copy of the same network runs over the pair results, and the remaining positions are filled in with one more combine each. The gate count therefore grows linearly with `W` and the depth grows with log2(`W`). The two-input combine is held in a cell of its own, so the same recursion can carry any associative operator. `W` must be a power of two and at least 2. `REG_OUT` chooses between a registered output and a purely combinational one.

Top module: `prefix_or_encoder`

## Requirements
- R1: Output bit `out_vec[b]` equals the OR of `in_vec[W-1:b]`, for every `b` from 0 to `W-1`.
- R2: The output always has the form of zeros followed by ones when read from bit `W-1` down to bit 0 (a thermometer word).
- R3: `out_vec[W-1]` equals `in_vec[W-1]`.
- R4: An all-zero input word produces an all-zero output word.
- R5: `out_vec[0]` equals the OR of all input bits.
- R6: With `REG_OUT`=1 the result for an input appears at the first rising clock edge after that input and holds until the next edge. With `REG_OUT`=0 the output follows the input with no clock involved.
- R7: With `REG_OUT`=1, a high `rst` at a rising edge clears `out_vec` to all zeros, whatever the input.
- R8: For `W`=4, input `4'b0010` gives output `4'b0011`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_vec | input | W | Input word; bit W-1 is the first position |
| out_vec | output | W | Thermometer word of running ORs from bit W-1 downward |

## Verification
In the registered build each result is due one rising edge after its input is applied. The bench drives a new word at every falling edge and compares the output at the next falling edge against the word driven one cycle earlier, so one vector is checked per cycle. Just after each new word is driven, the bench also confirms that the output still shows the previous result (R6). The combinational build is checked a short delay after each input change, with no clock edge in between.

// File: rtl/prefix_or_pkg.sv
package prefix_or_pkg;

  // True when n is a power of two no smaller than 2
  function automatic bit is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

  // The associative operator carried by the prefix network
  function automatic logic combine(input logic lhs, input logic rhs);
    return lhs | rhs;
  endfunction

endpackage

// File: rtl/prefix_or_cell.sv
module prefix_or_cell (
  input  logic a,
  input  logic b,
  output logic y
);
  assign y = prefix_or_pkg::combine(a, b);
endmodule

// File: rtl/prefix_or_net.sv
// Recursive prefix network. Index 0 is the first position.
// y[i] = x[0] op x[1] op ... op x[i]
module prefix_or_net #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam int HALF = W / 2;

  generate
    if (W == 1) begin : g_leaf
      assign y = x;
    end else begin : g_split
      logic [HALF-1:0] pair;
      logic [HALF-1:0] sub;

      // combine neighbouring pairs; half-size prefix gives odd positions
      for (genvar j = 0; j < HALF; j++) begin : g_pair
        prefix_or_cell u_pair (
          .a (x[2*j]),
          .b (x[2*j+1]),
          .y (pair[j])
        );
        assign y[2*j+1] = sub[j];
      end

      prefix_or_net #(.W(HALF)) u_half (
        .x (pair),
        .y (sub)
      );

      assign y[0] = x[0];

      // remaining positions: left neighbour's prefix with own bit
      for (genvar j = 1; j < HALF; j++) begin : g_fill
        prefix_or_cell u_fill (
          .a (sub[j-1]),
          .b (x[2*j]),
          .y (y[2*j])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/prefix_or_encoder.sv
module prefix_or_encoder #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_vec,
  output logic [W-1:0] out_vec
);
  localparam bit W_OK = prefix_or_pkg::is_pow2(W);

  logic [W-1:0] pos_in;
  logic [W-1:0] pos_out;
  logic [W-1:0] therm;

  // port bit W-1 is position 0 of the network
  for (genvar p = 0; p < W; p++) begin : g_order
    assign pos_in[p]      = in_vec[W-1-p];
    assign therm[W-1-p]   = pos_out[p];
  end

  prefix_or_net #(.W(W)) u_net (
    .x (pos_in),
    .y (pos_out)
  );

  initial begin
    assert (W_OK) else $error("prefix_or_encoder: W must be a power of two >= 2");
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] q;
      logic         past_ok = 1'b0;

      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= therm;
        past_ok <= !rst;
      end

      assign out_vec = q;

      // R7: reset clears the output on the next edge
      p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (out_vec == '0));

      // R2: output is always a thermometer word
      p_thermo_shape_r2: assert property (@(posedge clk) disable iff (rst)
        (((out_vec + 1'b1) & out_vec) == '0));

      // R3: first position copied through
      p_msb_follow_r3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        out_vec[W-1] == $past(in_vec[W-1]));

      // R5: last position is the OR of the whole word
      p_lsb_any_r5: assert property (@(posedge clk) disable iff (rst || !past_ok)
        out_vec[0] == $past(|in_vec));

      // R4: zero input gives zero output
      p_zero_in_r4: assert property (@(posedge clk) disable iff (rst || !past_ok)
        ($past(in_vec) == '0) |-> (out_vec == '0));
    end else begin : g_comb
      assign out_vec = therm;
    end
  endgenerate
endmodule

// File: tb/sim_prefix_or_encoder.sv
module sim_prefix_or_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] in0 = '0;
  logic [63:0] in1 = '0;
  logic [3:0]  in2 = '0;
  logic [15:0] out0;
  logic [63:0] out1;
  logic [3:0]  out2;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [63:0] prev [2];
  bit          have [2];

  always #10 clk = ~clk;

  prefix_or_encoder #(.W(16), .REG_OUT(1'b1)) u0 (.clk(clk), .rst(rst), .in_vec(in0), .out_vec(out0));
  prefix_or_encoder #(.W(64), .REG_OUT(1'b1)) u1 (.clk(clk), .rst(rst), .in_vec(in1), .out_vec(out1));
  prefix_or_encoder #(.W(4),  .REG_OUT(1'b0)) u2 (.clk(clk), .rst(rst), .in_vec(in2), .out_vec(out2));

  function automatic logic [63:0] ref_prefix(input logic [63:0] v, input int w);
    logic [63:0] r = '0;
    logic acc = 1'b0;
    for (int b = w - 1; b >= 0; b--) begin
      acc  = acc | v[b];
      r[b] = acc;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] get_out(input int which);
    return (which == 0) ? {48'd0, out0} : out1;
  endfunction

  // One vector per cycle: check the previous word, then drive the new one
  task automatic step(input int which, input logic [63:0] v);
    int w = (which == 0) ? 16 : 64;
    logic [63:0] act;
    logic [63:0] p;
    @(negedge clk);
    act = get_out(which);
    p = prev[which];
    if (have[which]) begin
      check("R1", act, ref_prefix(p, w));
      check("R3", {63'd0, act[w-1]}, {63'd0, p[w-1]});
      check("R5", {63'd0, act[0]}, {63'd0, |p});
      if (p == 64'd0) check("R4", act, 64'd0);
    end
    if (which == 0) in0 = v[15:0];
    else            in1 = v;
    #1;
    // R6: new word not yet visible before the next rising edge
    if (have[which]) check("R6", get_out(which), ref_prefix(p, w));
    prev[which] = v;
    have[which] = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    have[0] = 1'b0;
    have[1] = 1'b0;
    prev[0] = '0;
    prev[1] = '0;
    in0 = 16'hffff;
    in1 = '1;
    repeat (3) @(negedge clk);
    check("R7", {48'd0, out0}, 64'd0);
    check("R7", out1, 64'd0);
    rst = 1'b0;

    // exhaustive sweep of the 16-bit build
    for (int v = 0; v < 65536; v++) step(0, 64'(v));
    step(0, 64'h0);

    // synchronous reset in the middle of a run
    @(negedge clk);
    in0 = 16'hffff;
    rst = 1'b1;
    @(negedge clk);
    check("R7", {48'd0, out0}, 64'd0);
    rst = 1'b0;
    have[0] = 1'b0;
    @(negedge clk);
    check("R1", {48'd0, out0}, ref_prefix(64'hffff, 16));

    // 64-bit build: single-bit sweep, extremes, random words
    for (int b = 0; b < 64; b++) step(1, 64'd1 << b);
    step(1, '1);
    step(1, '0);
    step(1, 64'h8000_0000_0000_0000);
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] r = {$urandom, $urandom};
      step(1, r >> ($urandom % 64));
    end
    step(1, '0);

    // combinational 4-bit build
    for (int v = 0; v < 16; v++) begin
      in2 = 4'(v);
      #1;
      check("R6", {60'd0, out2}, ref_prefix(64'(v), 4));
    end
    in2 = 4'b0010;
    #1;
    check("R8", {60'd0, out2}, 64'h3);

    finish_run();
  end
endmodule